// File: doc/BRIEF.md
# Multi-channel descriptor queue controller

This block collects transfer descriptors from a simple word-write port and holds them in one small queue per channel, for up to sixteen channels. A descriptor is built by writing three staging words (source address, destination address, size) and is committed by a fourth write that names the target channel. Each channel reports how many descriptors wait in its queue and whether that queue is full. It also keeps sticky flags for overflow, low watermark and terminal count.

Descriptors leave one at a time towards a downstream transfer engine through a valid/ready output. Once `dsc_valid` is high, the descriptor and its channel number stay frozen until a cycle with `dsc_ready` high. The engine reports each finished descriptor with a one-cycle `done_valid` pulse carrying the channel number. At most one descriptor per channel is outstanding, so a channel is eligible again only after its completion pulse.

Channel enable is requested with set and clear pulses, and the readback shows when a stop has really taken effect. A next-free word gives the lowest idle channel for allocation, together with the enable readback bitmap.

Top module: `desc_queue_ctrl`

## Requirements
- R1: Writes with `wr_sel` 0, 1 and 2 stage the source, destination and size words. A write with `wr_sel` 3 and a data value below NUM_CH pushes the three staged words into the queue of that channel, and the descriptor later emitted carries exactly those words and that channel. A channel write with a value of NUM_CH or above is dropped.
- R2: Each channel's 6-bit pending count equals the descriptors queued and not yet handed out. Its full bit is 1 exactly when the count equals DEPTH.
- R3: A push to a full queue is dropped, the count stays unchanged, and the channel's overflow flag is set.
- R4: When a dispatch lowers a channel's pending count to its 4-bit low-watermark value, that channel's low-watermark flag is set.
- R5: Each channel counts its completions. When the count reaches the channel's nonzero 16-bit terminal value, the terminal-count flag is set and the count restarts from zero. A terminal value of 0 never sets the flag.
- R6: `next_free` bits 4:0 hold the lowest channel whose enable readback is 0, or NUM_CH if there is none. Bits 31:16 hold the enable readback bitmap, with zeros above NUM_CH, and bits 15:5 are zero.
- R7: The enable readback rises the cycle after an `en_set` pulse. After an `en_clr` pulse it stays 1 while a descriptor of that channel is outstanding, and falls on the clock edge that takes the completion pulse.
- R8: A dispatch picks, among channels that are enabled, not paused, not outstanding and not empty, the one with the lowest 2-bit priority value (0 highest). Ties go to the lower channel number.
- R9: While `dsc_valid` is high and `dsc_ready` is low, `dsc_valid`, the descriptor words and `dsc_chan` hold unchanged.
- R10: A descriptor whose size word has bit 24 set clears its channel's enable request when it completes. The channel then dispatches nothing more until a new `en_set`.
- R11: An `evt_clr` pulse clears that channel's overflow, low-watermark and terminal-count flags and restarts its completion count.
- R12: A channel with an outstanding descriptor is not dispatched again until its completion pulse arrives, even if the output slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_sel | input | 2 | 0 source, 1 destination, 2 size, 3 channel (commit) |
| wr_data | input | 32 | Write data |
| en_set | input | NUM_CH | Per-channel enable request pulse |
| en_clr | input | NUM_CH | Per-channel disable request pulse |
| pause | input | NUM_CH | Per-channel pause level |
| evt_clr | input | NUM_CH | Per-channel flag clear pulse |
| prio | input | 2*NUM_CH | Per-channel priority, 0 highest |
| lowmark | input | 4*NUM_CH | Per-channel low-watermark value |
| term_cnt | input | 16*NUM_CH | Per-channel terminal completion count |
| en_rb | output | NUM_CH | Enable readback |
| pend_cnt | output | 6*NUM_CH | Pending descriptor counts |
| q_full | output | NUM_CH | Queue full bits |
| lwm_flag | output | NUM_CH | Sticky low-watermark flags |
| tc_flag | output | NUM_CH | Sticky terminal-count flags |
| ovf_flag | output | NUM_CH | Sticky overflow flags |
| next_free | output | 32 | Lowest free channel and enable bitmap |
| dsc_valid | output | 1 | Descriptor offered downstream |
| dsc_ready | input | 1 | Downstream accepts descriptor |
| dsc_src | output | 32 | Source word |
| dsc_dst | output | 32 | Destination word |
| dsc_size | output | 32 | Size word, bit 24 auto-disable |
| dsc_chan | output | CH_W | Channel of the offered descriptor |
| done_valid | input | 1 | Completion pulse |
| done_chan | input | CH_W | Channel that completed |

## Verification
A wrong queue pointer or count shows on the next dispatch: the descriptor words or `pend_cnt` differ from what was pushed one cycle after the commit write. A wrong outstanding or enable state shows as a readback bit that falls too early or too late, or as a second dispatch of a channel before its completion pulse. A wrong arbitration choice shows as an out-of-order `dsc_chan` on the first load after release. A lost flag condition shows at the cycle after the pop or completion that should set it.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_SIZE = 2'd2,
    SEL_CHAN = 2'd3
  } wsel_e;

  localparam int AUTO_OFF_BIT = 24;
  localparam int CNT_W        = 6;
  localparam int TC_W         = 16;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] size;
  } desc_t;
endpackage

// File: rtl/dq_fifo.sv
module dq_fifo
  import dq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  desc_t            din,
  output desc_t            dout,
  output logic [CNT_W-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  desc_t          mem [DEPTH];
  logic [PW-1:0]  wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout = mem[rp];

  // R3: the channel logic must never push into a full queue
  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CNT_W'(DEPTH)));
  // R2: the arbiter must never pop an empty queue
  assert_no_pop_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/dq_chan.sv
module dq_chan
  import dq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             pause,
  input  logic             evt_clr,
  input  logic [3:0]       lowmark,
  input  logic [TC_W-1:0]  term,
  input  logic [CNT_W-1:0] count,
  input  logic             push_req,
  input  logic             pop,
  input  logic             pop_auto,
  input  logic             done,
  output logic             push_ok,
  output logic             eligible,
  output logic             enabled_rb,
  output logic             full,
  output logic             ovf_st,
  output logic             lwm_st,
  output logic             tc_st
);
  logic             req_q, busy_q, auto_q, done_ok;
  logic [TC_W-1:0]  done_cnt;
  logic [CNT_W-1:0] nxt_cnt;

  assign full       = (count == CNT_W'(DEPTH));
  assign push_ok    = push_req & ~full;
  assign eligible   = req_q & ~pause & ~busy_q & (count != '0);
  assign done_ok    = done & busy_q;
  assign enabled_rb = req_q | busy_q;
  assign nxt_cnt    = count + CNT_W'(push_ok) - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      busy_q   <= 1'b0;
      auto_q   <= 1'b0;
      ovf_st   <= 1'b0;
      lwm_st   <= 1'b0;
      tc_st    <= 1'b0;
      done_cnt <= '0;
    end else begin
      if (pop) begin
        busy_q <= 1'b1;
        auto_q <= pop_auto;
      end else if (done_ok) begin
        busy_q <= 1'b0;
      end
      // R7 / R10: request cleared by software or by an auto-off completion
      if (en_set) req_q <= 1'b1;
      else if (en_clr || (done_ok && auto_q)) req_q <= 1'b0;
      // R11: clear has precedence over new events
      if (evt_clr) begin
        ovf_st   <= 1'b0;
        lwm_st   <= 1'b0;
        tc_st    <= 1'b0;
        done_cnt <= '0;
      end else begin
        if (push_req && full) ovf_st <= 1'b1;
        if (pop && !push_ok && nxt_cnt == CNT_W'(lowmark)) lwm_st <= 1'b1;
        if (done_ok) begin
          if (term != '0 && done_cnt + 16'd1 == term) begin
            tc_st    <= 1'b1;
            done_cnt <= '0;
          end else begin
            done_cnt <= done_cnt + 16'd1;
          end
        end
      end
    end
  end

  assert_stop_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enabled_rb) |-> $past(en_clr || done));
  assert_one_in_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pop);
  assert_tc_from_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_st) |-> $past(done));
endmodule

// File: rtl/dq_arb.sv
module dq_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     elig,
  input  logic [2*NUM_CH-1:0]   prio,
  output logic [NUM_CH-1:0]     grant,
  output logic [CH_W-1:0]       idx,
  output logic                  any
);
  logic [2:0] best;

  always_comb begin
    best = 3'd4;
    idx  = '0;
    any  = 1'b0;
    // strict compare keeps the lower channel on equal priority (R8)
    for (int i = 0; i < NUM_CH; i++) begin
      if (elig[i] && {1'b0, prio[2*i +: 2]} < best) begin
        best = {1'b0, prio[2*i +: 2]};
        idx  = CH_W'(i);
        any  = 1'b1;
      end
    end
    grant = any ? (NUM_CH'(1) << idx) : '0;
  end

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == '0);
endmodule

// File: rtl/desc_queue_ctrl.sv
module desc_queue_ctrl
  import dq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [31:0]              wr_data,
  input  logic [NUM_CH-1:0]        en_set,
  input  logic [NUM_CH-1:0]        en_clr,
  input  logic [NUM_CH-1:0]        pause,
  input  logic [NUM_CH-1:0]        evt_clr,
  input  logic [2*NUM_CH-1:0]      prio,
  input  logic [4*NUM_CH-1:0]      lowmark,
  input  logic [TC_W*NUM_CH-1:0]   term_cnt,
  output logic [NUM_CH-1:0]        en_rb,
  output logic [CNT_W*NUM_CH-1:0]  pend_cnt,
  output logic [NUM_CH-1:0]        q_full,
  output logic [NUM_CH-1:0]        lwm_flag,
  output logic [NUM_CH-1:0]        tc_flag,
  output logic [NUM_CH-1:0]        ovf_flag,
  output logic [31:0]              next_free,
  output logic                     dsc_valid,
  input  logic                     dsc_ready,
  output logic [31:0]              dsc_src,
  output logic [31:0]              dsc_dst,
  output logic [31:0]              dsc_size,
  output logic [CH_W-1:0]          dsc_chan,
  input  logic                     done_valid,
  input  logic [CH_W-1:0]          done_chan
);
  desc_t              stage, out_d;
  desc_t              fifo_out [NUM_CH];
  logic [CNT_W-1:0]   cnt      [NUM_CH];
  logic [NUM_CH-1:0]  push_req, push_ok, pop, elig, grant, done_v;
  logic [CH_W-1:0]    win_idx, out_ch;
  logic               any, out_valid, ch_hit;
  logic [4:0]         nf;

  // R1: staging and commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        SEL_SRC:  stage.src  <= wr_data;
        SEL_DST:  stage.dst  <= wr_data;
        SEL_SIZE: stage.size <= wr_data;
        default:  ;
      endcase
    end
  end

  assign ch_hit = wr_en && (wsel_e'(wr_sel) == SEL_CHAN) && (wr_data < 32'(NUM_CH));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign push_req[g] = ch_hit && (wr_data[CH_W-1:0] == CH_W'(g));
    assign pop[g]      = grant[g] & ~out_valid;
    assign done_v[g]   = done_valid && (done_chan == CH_W'(g));

    dq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_ok[g]), .pop(pop[g]),
      .din(stage), .dout(fifo_out[g]), .count(cnt[g]));

    dq_chan #(.DEPTH(DEPTH)) u_chan (
      .clk(clk), .rst_n(rst_n), .en_set(en_set[g]), .en_clr(en_clr[g]),
      .pause(pause[g]), .evt_clr(evt_clr[g]), .lowmark(lowmark[4*g +: 4]),
      .term(term_cnt[TC_W*g +: TC_W]), .count(cnt[g]), .push_req(push_req[g]),
      .pop(pop[g]), .pop_auto(fifo_out[g].size[AUTO_OFF_BIT]), .done(done_v[g]),
      .push_ok(push_ok[g]), .eligible(elig[g]), .enabled_rb(en_rb[g]),
      .full(q_full[g]), .ovf_st(ovf_flag[g]), .lwm_st(lwm_flag[g]),
      .tc_st(tc_flag[g]));

    assign pend_cnt[CNT_W*g +: CNT_W] = cnt[g];
  end

  dq_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .prio(prio),
    .grant(grant), .idx(win_idx), .any(any));

  // output slot: loads only when empty, holds under back-pressure (R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_d     <= '0;
      out_ch    <= '0;
    end else if (out_valid) begin
      if (dsc_ready) out_valid <= 1'b0;
    end else if (any) begin
      out_valid <= 1'b1;
      out_d     <= fifo_out[win_idx];
      out_ch    <= win_idx;
    end
  end

  assign dsc_valid = out_valid;
  assign dsc_src   = out_d.src;
  assign dsc_dst   = out_d.dst;
  assign dsc_size  = out_d.size;
  assign dsc_chan  = out_ch;

  // R6: lowest idle channel plus readback bitmap
  always_comb begin
    nf = 5'(NUM_CH);
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (!en_rb[i]) nf = 5'(i);
    end
  end
  assign next_free = {16'(en_rb), 11'b0, nf};

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(out_d) && $stable(out_ch)));
endmodule

// File: tb/desc_queue_ctrl_tb_top.sv
`timescale 1ns/1ps
module desc_queue_ctrl_tb_top;
  localparam int N = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] en_set = '0, en_clr = '0, pause = '0, evt_clr = '0;
  logic [2*N-1:0] prio = '0;
  logic [4*N-1:0] lowmark = '0;
  logic [16*N-1:0] term_cnt = '0;
  logic [N-1:0] en_rb, q_full, lwm_flag, tc_flag, ovf_flag;
  logic [6*N-1:0] pend_cnt;
  logic [31:0] next_free, dsc_src, dsc_dst, dsc_size;
  logic dsc_valid, dsc_ready = 1'b0, done_valid = 1'b0;
  logic [CW-1:0] dsc_chan, done_chan = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  desc_queue_ctrl #(.NUM_CH(N), .DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .en_set(en_set), .en_clr(en_clr), .pause(pause), .evt_clr(evt_clr),
    .prio(prio), .lowmark(lowmark), .term_cnt(term_cnt), .en_rb(en_rb),
    .pend_cnt(pend_cnt), .q_full(q_full), .lwm_flag(lwm_flag), .tc_flag(tc_flag),
    .ovf_flag(ovf_flag), .next_free(next_free), .dsc_valid(dsc_valid),
    .dsc_ready(dsc_ready), .dsc_src(dsc_src), .dsc_dst(dsc_dst),
    .dsc_size(dsc_size), .dsc_chan(dsc_chan), .done_valid(done_valid),
    .done_chan(done_chan));

  // {channel, source, destination, size}
  localparam logic [97:0] VEC [5] = '{
    {2'd0, 32'h1000_0000, 32'h2000_0000, 32'h0000_0040},
    {2'd3, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h00FF_FFFF},
    {2'd1, 32'h0000_0004, 32'hFFFF_FFF0, 32'h0000_0001},
    {2'd2, 32'h8000_0001, 32'h7FFF_FFFE, 32'h0080_0000},
    {2'd0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input logic [31:0] ch, input logic [31:0] s,
                      input logic [31:0] d, input logic [31:0] z);
    wr(2'd0, s); wr(2'd1, d); wr(2'd2, z); wr(2'd3, ch);
  endtask

  task automatic pulse_done(input logic [CW-1:0] ch);
    done_valid = 1'b1; done_chan = ch;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic serve(output logic [CW-1:0] ch);
    int n = 0;
    while (!dsc_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    ch = dsc_chan;
    dsc_ready = 1'b1;
    @(negedge clk);
    dsc_ready = 1'b0;
    pulse_done(ch);
  endtask

  function automatic logic [31:0] pc(input int ch);
    return 32'(pend_cnt[6*ch +: 6]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("reset R9 valid", 32'(dsc_valid), 0);
    chk("reset R6 next_free", next_free, 32'h0000_0000);
    chk("reset R2 pending", 32'(pend_cnt), 0);

    en_set = 4'hF; @(negedge clk); en_set = '0;

    // vector table: push, dispatch, hold, accept, complete
    for (int k = 0; k < 5; k++) begin
      logic [1:0] c;
      c = VEC[k][97:96];
      push(32'(c), VEC[k][95:64], VEC[k][63:32], VEC[k][31:0]);
      chk("R2 pending after commit", pc(c), 1);
      chk("R1 not yet offered", 32'(dsc_valid), 0);
      @(negedge clk);
      chk("R1 valid", 32'(dsc_valid), 1);
      chk("R1 src", dsc_src, VEC[k][95:64]);
      chk("R1 dst", dsc_dst, VEC[k][63:32]);
      chk("R1 size", dsc_size, VEC[k][31:0]);
      chk("R1 chan", 32'(dsc_chan), 32'(c));
      @(negedge clk);
      chk("R9 held valid", 32'(dsc_valid), 1);
      chk("R9 held src", dsc_src, VEC[k][95:64]);
      dsc_ready = 1'b1; @(negedge clk); dsc_ready = 1'b0;
      chk("R9 released", 32'(dsc_valid), 0);
      pulse_done(c);
    end
    chk("R6 all enabled", next_free, 32'h000F_0004);

    // invalid channel number dropped
    push(32'd4, 32'h1, 32'h2, 32'h3);
    @(negedge clk);
    chk("R1 bad chan dropped", 32'(pend_cnt), 0);
    chk("R1 bad chan no offer", 32'(dsc_valid), 0);

    // full and overflow on channel 1
    pause[1] = 1'b1;
    for (int k = 0; k < 4; k++) push(32'd1, 32'(k), 32'(k + 16), 32'h10);
    chk("R2 pending full", pc(1), 4);
    chk("R2 full bit", 32'(q_full[1]), 1);
    push(32'd1, 32'hEE, 32'hEE, 32'h10);
    chk("R3 pending unchanged", pc(1), 4);
    chk("R3 overflow flag", 32'(ovf_flag[1]), 1);
    evt_clr[1] = 1'b1; @(negedge clk); evt_clr[1] = 1'b0;
    chk("R11 overflow cleared", 32'(ovf_flag[1]), 0);

    lowmark[7:4] = 4'd2;
    term_cnt[31:16] = 16'd3;
    pause[1] = 1'b0;
    @(negedge clk);
    chk("R4 first pop count", pc(1), 3);
    chk("R4 not yet", 32'(lwm_flag[1]), 0);
    chk("R2 full cleared", 32'(q_full[1]), 0);
    serve(got);
    chk("R1 fifo order chan", 32'(got), 1);
    @(negedge clk);
    chk("R4 count at mark", pc(1), 2);
    chk("R4 low mark set", 32'(lwm_flag[1]), 1);
    chk("R1 fifo order src", dsc_src, 32'd1);
    serve(got);
    chk("R5 two done no tc", 32'(tc_flag[1]), 0);
    serve(got);
    chk("R5 tc set", 32'(tc_flag[1]), 1);
    serve(got);
    chk("R2 drained", pc(1), 0);

    // enable handshake on channel 2
    push(32'd2, 32'hA, 32'hB, 32'hC);
    @(negedge clk);
    chk("R7 dispatched", 32'(dsc_valid), 1);
    en_clr[2] = 1'b1; @(negedge clk); en_clr[2] = 1'b0;
    chk("R7 readback held", 32'(next_free[18]), 1);
    dsc_ready = 1'b1; @(negedge clk); dsc_ready = 1'b0;
    chk("R7 held after accept", 32'(next_free[18]), 1);
    pulse_done(2'd2);
    chk("R7 readback falls", 32'(next_free[18]), 0);
    chk("R6 lowest free", next_free, 32'h000B_0002);

    // priority ordering
    prio = {2'd1, 2'd3, 2'd1, 2'd2};
    pause = 4'hF;
    en_set[2] = 1'b1; @(negedge clk); en_set[2] = 1'b0;
    for (int k = 0; k < 4; k++) push(32'(k), 32'(k), 32'(k), 32'h4);
    pause = '0;
    serve(got); chk("R8 first", 32'(got), 1);
    serve(got); chk("R8 tie to lower", 32'(got), 3);
    serve(got); chk("R8 third", 32'(got), 0);
    serve(got); chk("R8 last", 32'(got), 2);

    // auto-disable
    push(32'd0, 32'h55, 32'h66, 32'h0100_0010);
    serve(got);
    chk("R10 readback off", 32'(next_free[16]), 0);
    push(32'd0, 32'h77, 32'h88, 32'h20);
    repeat (3) @(negedge clk);
    chk("R10 no dispatch", 32'(dsc_valid), 0);
    chk("R10 still pending", pc(0), 1);
    en_set[0] = 1'b1; @(negedge clk); en_set[0] = 1'b0;
    @(negedge clk);
    chk("R10 resumes", 32'(dsc_valid), 1);

    // one outstanding per channel
    push(32'd0, 32'h99, 32'hAA, 32'h20);
    dsc_ready = 1'b1; @(negedge clk); dsc_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 no second dispatch", 32'(dsc_valid), 0);
    chk("R12 still queued", pc(0), 1);
    pulse_done(2'd0);
    @(negedge clk);
    chk("R12 after done", 32'(dsc_valid), 1);
    chk("R12 next src", dsc_src, 32'h99);
    serve(got);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule